// File: doc/BRIEF.md
# SPI Interrupt Status and Masking Unit

This unit gathers the interrupt events of an SPI controller's transfer engine into a raw status register. It has three event sources: transmit done, receive ready and receive overflow. Each event stays latched until software clears it. Software clears a bit by writing a 1 to the matching position of a clear register.

A control register holds per-event enable bits. These bits sit at other positions than the status bits, so the unit moves them onto the status layout. It then ANDs them with the raw status to form a masked status. One interrupt line goes high whenever any masked bit is set.

Software reaches the registers through a simple strobe interface with a combinational read path. The raw status and masked status registers are read-only.

Top module: `spiIrqUnit`

## Requirements
- R1: The raw status register is at address 1. Its bit 0 is transmit done, bit 1 is receive ready and bit 2 is receive overflow. All other read bits are zero.
- R2: A high on bit k of the event input sets raw bit k at the next clock edge. A set bit stays set until it is cleared.
- R3: A high on the transfer-end event input sets raw bits 0 and 1 together at the next clock edge.
- R4: A write to the clear register (address 3) clears every raw bit whose write-data bit is 1. Bits written as 0 are untouched. The clear register reads as zero.
- R5: When a set event and a clear arrive in the same cycle for the same bit, the bit ends up set.
- R6: The control register is at address 0 and reads back the full written value. Its bit 5 enables status bit 0, bit 4 enables status bit 1, and bit 6 enables status bit 2.
- R7: The masked status register is at address 2. It equals the raw status ANDed with the remapped enables, with no added cycle.
- R8: The interrupt output is high exactly when the masked status is nonzero. It falls in the cycle the raw bit is cleared.
- R9: Writes to addresses 1 and 2 change no state.
- R10: Reset clears the raw status and the control register, and holds the interrupt low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regAddr | input | ADDR_W | Register word address |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Read data for regAddr, combinational |
| evtSet | input | 3 | Per-bit event pulses from the transfer engine |
| evtXferEnd | input | 1 | End-of-counted-transfer pulse |
| irq | output | 1 | Interrupt line |

## Verification
The assertions assume that events and writes are sampled only at clock edges. They also assume that the address is stable while the write strobe is high. The bench drives every input on the falling edge and holds it for one full cycle, so both assumptions hold. A cleared bit is assumed to stay low only when no set event for that bit arrives in the same cycle. The clear-path stimulus keeps the events idle except in the one deliberate set-versus-clear test.

// File: rtl/spiIrqPkg.sv
package spiIrqPkg;
  localparam int RAW_W = 3;
  localparam int BIT_TXDONE = 0;
  localparam int BIT_RXRDY = 1;
  localparam int BIT_RXOVF = 2;
  localparam int EN_TXDONE = 5;
  localparam int EN_RXRDY = 4;
  localparam int EN_RXOVF = 6;
  localparam int ADR_CTRL = 0;
  localparam int ADR_RAW = 1;
  localparam int ADR_MASK = 2;
  localparam int ADR_CLEAR = 3;

  typedef enum logic [1:0] {
    RD_CTRL = 2'd0,
    RD_RAW  = 2'd1,
    RD_MASK = 2'd2,
    RD_ZERO = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic wrCtrl;
    logic wrClear;
    rdSel_e rdSel;
  } strobe_t;

  function automatic int enPos(input int statusBit);
    case (statusBit)
      BIT_TXDONE: return EN_TXDONE;
      BIT_RXRDY: return EN_RXRDY;
      default: return EN_RXOVF;
    endcase
  endfunction
endpackage

// File: rtl/spiIrqCtrl.sv
module spiIrqCtrl
  import spiIrqPkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output strobe_t           strobes
);
  always_comb begin
    strobes = '{wrCtrl: 1'b0, wrClear: 1'b0, rdSel: RD_ZERO};
    if (regAddr == ADDR_W'(ADR_CTRL)) begin
      strobes.wrCtrl = regWrEn;
      strobes.rdSel = RD_CTRL;
    end else if (regAddr == ADDR_W'(ADR_RAW)) begin
      strobes.rdSel = RD_RAW;
    end else if (regAddr == ADDR_W'(ADR_MASK)) begin
      strobes.rdSel = RD_MASK;
    end else if (regAddr == ADDR_W'(ADR_CLEAR)) begin
      strobes.wrClear = regWrEn;
    end
  end
endmodule

// File: rtl/spiIrqDatapath.sv
module spiIrqDatapath
  import spiIrqPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic [RAW_W-1:0]  evtSet,
  input  logic              evtXferEnd,
  output logic [DATA_W-1:0] rdData,
  output logic [RAW_W-1:0]  rawStat,
  output logic [RAW_W-1:0]  maskStat,
  output logic              irq
);
  logic [DATA_W-1:0] ctrlReg;
  logic [RAW_W-1:0] enMap;
  logic [RAW_W-1:0] setVec;

  always_ff @(posedge clk) begin
    if (!rstN) ctrlReg <= '0;
    else if (strobes.wrCtrl) ctrlReg <= wrData;
  end

  for (genvar i = 0; i < RAW_W; i++) begin : g_bit
    localparam int EP = enPos(i);
    localparam bit IS_END = (i == BIT_TXDONE) || (i == BIT_RXRDY);
    assign enMap[i] = ctrlReg[EP];
    assign setVec[i] = evtSet[i] | (IS_END & evtXferEnd);
    always_ff @(posedge clk) begin
      if (!rstN) rawStat[i] <= 1'b0;
      else if (setVec[i]) rawStat[i] <= 1'b1;
      else if (strobes.wrClear && wrData[i]) rawStat[i] <= 1'b0;
    end
  end

  assign maskStat = rawStat & enMap;
  assign irq = |maskStat;

  always_comb begin
    unique case (strobes.rdSel)
      RD_CTRL: rdData = ctrlReg;
      RD_RAW:  rdData = DATA_W'(rawStat);
      RD_MASK: rdData = DATA_W'(maskStat);
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/spiIrqUnit.sv
module spiIrqUnit
  import spiIrqPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [2:0]        evtSet,
  input  logic              evtXferEnd,
  output logic              irq
);
  strobe_t strobes;
  logic [RAW_W-1:0] rawStat;
  logic [RAW_W-1:0] maskStat;

  spiIrqCtrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .regWrEn(regWrEn), .regAddr(regAddr), .strobes(strobes)
  );

  spiIrqDatapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(regWrData),
    .evtSet(evtSet), .evtXferEnd(evtXferEnd), .rdData(regRdData),
    .rawStat(rawStat), .maskStat(maskStat), .irq(irq)
  );
endmodule

// File: rtl/spiIrqChecker.sv
module spiIrqChecker #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic [2:0]        evtSet,
  input logic              evtXferEnd,
  input logic [2:0]        rawStat,
  input logic              irq
);
  logic clrWr;
  assign clrWr = regWrEn && (regAddr == ADDR_W'(3));

  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rstN)
    evtSet[2] |=> rawStat[2]);
  a_r3_xfer_end_sets: assert property (@(posedge clk) disable iff (!rstN)
    evtXferEnd |=> (rawStat[1:0] == 2'b11));
  a_r4_clear_bit0: assert property (@(posedge clk) disable iff (!rstN)
    (clrWr && regWrData[0] && !evtSet[0] && !evtXferEnd) |=> !rawStat[0]);
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (clrWr && regWrData[0] && evtSet[0]) |=> rawStat[0]);
  a_r8_irq_needs_raw: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (rawStat != 3'b000));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!clrWr && evtSet == 3'b000 && !evtXferEnd) |=> $stable(rawStat));
endmodule

bind spiIrqUnit spiIrqChecker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .evtSet(evtSet), .evtXferEnd(evtXferEnd),
  .rawStat(rawStat), .irq(irq)
);

// File: tb/spiIrqUnit_tb.sv
module spiIrqUnit_tb_top;
  localparam int DW = 32;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [DW-1:0] regWrData = '0;
  logic [DW-1:0] regRdData;
  logic [2:0] evtSet = '0;
  logic evtXferEnd = 1'b0;
  logic irq;

  int nRun = 0;
  int nFail = 0;
  logic [2:0] expRaw = '0;
  logic [DW-1:0] expCtrl = '0;

  always #2 clk = ~clk;

  spiIrqUnit #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .evtSet(evtSet),
    .evtXferEnd(evtXferEnd), .irq(irq)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [DW-1:0] v);
    regAddr = AW'(a);
    #0.5;
    v = regRdData;
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = AW'(a); regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic fire(input logic [2:0] e, input logic xe);
    @(negedge clk);
    evtSet = e; evtXferEnd = xe;
    @(negedge clk);
    evtSet = '0; evtXferEnd = 1'b0;
  endtask

  function automatic logic [2:0] remap(input logic [DW-1:0] c);
    return {c[6], c[4], c[5]};
  endfunction

  task automatic verifyAll(input string req);
    logic [DW-1:0] v;
    logic [2:0] m;
    m = expRaw & remap(expCtrl);
    rd(1, v); check({req, " R1 raw"}, v, DW'(expRaw));
    rd(2, v); check({req, " R7 mask"}, v, DW'(m));
    rd(0, v); check({req, " R6 ctrl"}, v, expCtrl);
    check({req, " R8 irq"}, DW'(irq), DW'(|m));
  endtask

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    // R10: state after reset
    rstN = 1'b1;
    @(negedge clk);
    verifyAll("R10 reset");
    rd(3, v); check("R4 clear reads zero", v, '0);

    // R2, R6, R7, R8: sweep raw patterns against enable patterns
    for (int r = 0; r < 8; r++) begin
      for (int e = 0; e < 8; e++) begin
        wr(3, DW'(7)); expRaw = '0;
        expCtrl = {24'h00A5_00, 1'b0, e[2], e[0], e[1], 4'b0011};
        wr(0, expCtrl);
        fire(3'(r), 1'b0); expRaw = 3'(r);
        verifyAll("R2 sweep");
      end
    end

    // R4: clear patterns from all-set
    expCtrl = 32'h0000_0070; wr(0, expCtrl);
    for (int c = 0; c < 8; c++) begin
      fire(3'b111, 1'b0); expRaw = 3'b111;
      wr(3, DW'(c) | 32'hFFFF_FFF8); expRaw = expRaw & ~3'(c);
      verifyAll("R4 clear");
    end

    // R8: irq falls in the cycle the clear lands
    wr(3, DW'(7)); expRaw = '0;
    fire(3'b100, 1'b0);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = AW'(3); regWrData = DW'(4);
    @(posedge clk); #0.5;
    check("R8 irq fall same cycle", DW'(irq), '0);
    @(negedge clk); regWrEn = 1'b0; regWrData = '0; expRaw = '0;

    // R3: transfer end sets bits 0 and 1
    fire(3'b000, 1'b1); expRaw = 3'b011;
    verifyAll("R3 xfer end");

    // R5: set wins over clear
    fire(3'b111, 1'b0);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = AW'(3); regWrData = DW'(7); evtSet = 3'b001;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0; evtSet = '0; expRaw = 3'b001;
    verifyAll("R5 set wins");

    // R9: writes to read-only registers
    wr(1, 32'hFFFF_FFFF);
    verifyAll("R9 raw write");
    wr(2, 32'h0000_0000);
    verifyAll("R9 mask write");

    // R10: reset mid-operation
    fire(3'b111, 1'b0);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1; expRaw = '0; expCtrl = '0;
    verifyAll("R10 reset again");

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule